// File: doc/BRIEF.md
# Keyed Software Warm-Reset Controller

This block produces the warm reset for a main power domain. Software asks for the reset by writing a 4-bit key into either of two control banks. An active-low reset-request pin can ask for it too. Only the exact key value 4'b0110 arms a request. Every other value, including the power-on value 4'b1111, is inert. Both software banks and the synchronised pin feed a single sequencer, so all three sources have the same effect.

A secondary domain can be marked as independent. In that case the sequencer first raises an isolation request and waits for the secondary domain to acknowledge it. Only then does it drive the main-domain reset low, and the secondary reset is left alone. When the secondary domain is not independent, the isolation step is skipped and both domains are warm-reset together.

The low phase lasts a programmable number of cycles, never fewer than 16. When the reset is released, any key field holding the arming value returns to 4'b1111, so the sequence cannot retrigger. A status register holds one sticky cause bit per source and is cleared by writing 1. Only the power-on reset clears this register and the key fields.

Top module: `warm_rst_keyed_ctrl`

## Requirements
- R1: After power-on reset, both key fields read 4'b1111, `cause_q` reads 3'b000, `iso_req` is 0, and both `main_wrst_n` and `sec_wrst_n` are 1.
- R2: A key field value other than 4'b0110 starts no sequence and leaves all three reset-side outputs unchanged. A written value is readable on the field's key output one cycle after the write.
- R3: When `sec_indep` is 1 at the start of a sequence, `iso_req` rises two cycles after a key write. `main_wrst_n` stays high until `iso_ack` is seen, then falls one cycle after the acknowledge is sampled. `sec_wrst_n` stays high, `iso_req` stays high for the whole low phase, and `iso_req` drops in the same cycle that `main_wrst_n` rises.
- R4: When `sec_indep` is 0 at the start of a sequence, `main_wrst_n` and `sec_wrst_n` fall together two cycles after a key write and rise together, and `iso_req` stays 0.
- R5: The reset stays low for `assert_cycles` cycles, or for 16 cycles if `assert_cycles` is below 16.
- R6: In the cycle after the reset is released, every key field holding 4'b0110 returns to 4'b1111, and no new sequence follows.
- R7: A falling edge on `rst_req_pin_n` passes through a two-flop synchroniser. It starts the same sequence three cycles after the pin falls. Holding the pin low or releasing it starts nothing further.
- R8: The `cause_q` register has one sticky bit per source: bit 0 is bank A, bit 1 is bank B, bit 2 is the pin. A bit is set by a bank write of 4'b0110 or by a pin falling edge. Causes that arrive together set all of their bits. Writing 1 to a bit through `clr_cause_we`/`clr_cause_data` clears only that bit.
- R9: A request that arrives while a sequence is running starts no second sequence, but its cause bit is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous active low, released synchronously inside the block |
| bank_a_we | input | 1 | Write strobe for the bank A key field |
| bank_a_wdata | input | 4 | Write data for the bank A key field |
| bank_b_we | input | 1 | Write strobe for the bank B key field |
| bank_b_wdata | input | 4 | Write data for the bank B key field |
| clr_cause_we | input | 1 | Write strobe for clearing cause bits |
| clr_cause_data | input | 3 | Cause bits to clear, one bit per cause (write 1 to clear) |
| rst_req_pin_n | input | 1 | Asynchronous active-low reset-request pin |
| sec_indep | input | 1 | 1 when the secondary domain runs independently |
| assert_cycles | input | CNT_W | Requested low-phase length in cycles |
| iso_ack | input | 1 | Isolation acknowledge from the secondary domain |
| bank_a_key | output | 4 | Current bank A key field |
| bank_b_key | output | 4 | Current bank B key field |
| cause_q | output | 3 | Sticky reset-cause bits |
| iso_req | output | 1 | Isolation request to the secondary domain |
| main_wrst_n | output | 1 | Main-domain warm reset, active low |
| sec_wrst_n | output | 1 | Secondary-domain warm reset, active low |

## Verification
The assertions rely on the following input behaviour:
- `iso_ack` is raised only while `iso_req` is high.
- No key field is written with 4'b0110 in the exact cycle that a key field is restored.
- `sec_indep` and `assert_cycles` may change between sequences.

The stimulus meets these conditions. It raises the acknowledge for one cycle some time after the request is seen. It injects in-flight requests only in the middle of the low phase. It sets the configuration inputs before each trigger. Checking the release and restore cycles is left to the bench's cycle-exact scoreboard.

// File: rtl/wrk_pkg.sv
package wrk_pkg;
  localparam int KEY_W = 4;
  localparam logic [KEY_W-1:0] KEY_ARM  = 4'b0110;
  localparam logic [KEY_W-1:0] KEY_REST = 4'b1111;
  localparam int NBANK  = 2;
  localparam int NCAUSE = NBANK + 1;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ISO_REQ,
    SQ_ISO_WAIT,
    SQ_ASSERT,
    SQ_RELEASE
  } seq_state_e;
endpackage

// File: rtl/wrk_key_field.sv
module wrk_key_field
  import wrk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_data,
  input  logic             rel_clr,
  output logic [KEY_W-1:0] key_q,
  output logic             armed,
  output logic             arm_wr
);
  logic [KEY_W-1:0] key_d;
  logic             key_en;

  assign armed  = (key_q == KEY_ARM);
  assign arm_wr = wr_en && (wr_data == KEY_ARM);

  // software write takes priority over the release-time restore
  always_comb begin
    key_d  = key_q;
    key_en = 1'b0;
    if (rel_clr && armed) begin
      key_d  = KEY_REST;
      key_en = 1'b1;
    end
    if (wr_en) begin
      key_d  = wr_data;
      key_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= KEY_REST;
    end else if (key_en) begin
      key_q <= key_d;
    end
  end
endmodule

// File: rtl/wrk_pin_sync.sv
module wrk_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;
  logic              pin_s;

  assign pin_s = sh_q[STAGES-1];
  assign fall  = prev_q && !pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin_n};
      prev_q <= pin_s;
    end
  end
endmodule

// File: rtl/wrk_cause_log.sv
module wrk_cause_log #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] cause_q
);
  logic [N-1:0] clr_mask;
  logic [N-1:0] cause_d;
  logic         cause_en;

  assign clr_mask = clr_we ? clr_data : '0;

  // a new cause in the same cycle as its clear wins
  always_comb begin
    cause_d  = (cause_q & ~clr_mask) | set_i;
    cause_en = (|set_i) || clr_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/wrk_seq_fsm.sv
module wrk_seq_fsm
  import wrk_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int MIN_ASSERT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             indep,
  input  logic [CNT_W-1:0] len,
  input  logic             iso_ack,
  output logic             iso_req,
  output logic             main_n,
  output logic             sec_n,
  output logic             rel_clr
);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(MIN_ASSERT);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             indep_q, indep_d;
  logic [CNT_W-1:0] len_eff;
  logic             iso_d, main_d, sec_d;

  assign len_eff = (len < MIN_LEN) ? MIN_LEN : len;
  assign rel_clr = (st_q == SQ_RELEASE);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    indep_d = indep_q;
    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          indep_d = indep;
          len_d   = len_eff;
          if (indep) begin
            st_d = SQ_ISO_REQ;
          end else begin
            st_d  = SQ_ASSERT;
            cnt_d = len_eff - ONE;
          end
        end
      end
      SQ_ISO_REQ:  st_d = SQ_ISO_WAIT;
      SQ_ISO_WAIT: begin
        if (iso_ack) begin
          st_d  = SQ_ASSERT;
          cnt_d = len_q - ONE;
        end
      end
      SQ_ASSERT: begin
        if (cnt_q == '0) begin
          st_d = SQ_RELEASE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      SQ_RELEASE: st_d = SQ_IDLE;
      default:    st_d = SQ_IDLE;
    endcase
  end

  // outputs are registered from the next state so they never glitch
  always_comb begin
    iso_d  = (st_d == SQ_ISO_REQ) || (st_d == SQ_ISO_WAIT) ||
             ((st_d == SQ_ASSERT) && indep_d);
    main_d = (st_d != SQ_ASSERT);
    sec_d  = !((st_d == SQ_ASSERT) && !indep_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      len_q   <= MIN_LEN;
      indep_q <= 1'b0;
      iso_req <= 1'b0;
      main_n  <= 1'b1;
      sec_n   <= 1'b1;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      indep_q <= indep_d;
      iso_req <= iso_d;
      main_n  <= main_d;
      sec_n   <= sec_d;
    end
  end
endmodule

// File: rtl/warm_rst_keyed_ctrl.sv
module warm_rst_keyed_ctrl
  import wrk_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int MIN_ASSERT  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_a_we,
  input  logic [KEY_W-1:0]  bank_a_wdata,
  input  logic              bank_b_we,
  input  logic [KEY_W-1:0]  bank_b_wdata,
  input  logic              clr_cause_we,
  input  logic [NCAUSE-1:0] clr_cause_data,
  input  logic              rst_req_pin_n,
  input  logic              sec_indep,
  input  logic [CNT_W-1:0]  assert_cycles,
  input  logic              iso_ack,
  output logic [KEY_W-1:0]  bank_a_key,
  output logic [KEY_W-1:0]  bank_b_key,
  output logic [NCAUSE-1:0] cause_q,
  output logic              iso_req,
  output logic              main_wrst_n,
  output logic              sec_wrst_n
);
  logic [1:0] rsync_q;
  logic       sys_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign sys_rst_n = rsync_q[1];

  logic [NBANK-1:0]            bank_we;
  logic [NBANK-1:0][KEY_W-1:0] bank_wd;
  logic [NBANK-1:0][KEY_W-1:0] bank_key;
  logic [NBANK-1:0]            bank_armed;
  logic [NBANK-1:0]            bank_arm_wr;
  logic                        rel_clr;
  logic                        pin_fall;
  logic                        start;

  assign bank_we = {bank_b_we, bank_a_we};
  assign bank_wd = {bank_b_wdata, bank_a_wdata};

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    wrk_key_field u_key (
      .clk     (clk),
      .rst_n   (sys_rst_n),
      .wr_en   (bank_we[g]),
      .wr_data (bank_wd[g]),
      .rel_clr (rel_clr),
      .key_q   (bank_key[g]),
      .armed   (bank_armed[g]),
      .arm_wr  (bank_arm_wr[g])
    );
  end

  assign bank_a_key = bank_key[0];
  assign bank_b_key = bank_key[1];

  wrk_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .pin_n (rst_req_pin_n),
    .fall  (pin_fall)
  );

  assign start = (|bank_armed) || pin_fall;

  wrk_seq_fsm #(.CNT_W(CNT_W), .MIN_ASSERT(MIN_ASSERT)) u_seq (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .start   (start),
    .indep   (sec_indep),
    .len     (assert_cycles),
    .iso_ack (iso_ack),
    .iso_req (iso_req),
    .main_n  (main_wrst_n),
    .sec_n   (sec_wrst_n),
    .rel_clr (rel_clr)
  );

  wrk_cause_log #(.N(NCAUSE)) u_cause (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .set_i    ({pin_fall, bank_arm_wr}),
    .clr_we   (clr_cause_we),
    .clr_data (clr_cause_data),
    .cause_q  (cause_q)
  );
endmodule

// File: rtl/wrk_checker.sv
module wrk_checker
  import wrk_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int MIN_ASSERT = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iso_ack,
  input logic              iso_req,
  input logic              main_wrst_n,
  input logic              sec_wrst_n,
  input logic [KEY_W-1:0]  bank_a_key,
  input logic [KEY_W-1:0]  bank_b_key,
  input logic [NCAUSE-1:0] cause_q,
  input logic              clr_cause_we,
  input logic [NCAUSE-1:0] clr_cause_data
);
  logic [CNT_W:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (main_wrst_n) begin
      low_run <= '0;
    end else if (low_run != '1) begin
      low_run <= low_run + 1'b1;
    end
  end

  p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (main_wrst_n && sec_wrst_n && !iso_req && cause_q == '0));

  p_iso_before_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(main_wrst_n) && sec_wrst_n) |-> $past(iso_ack));

  p_iso_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_wrst_n && sec_wrst_n) |-> iso_req);

  p_iso_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_wrst_n) |-> !iso_req);

  p_shared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_wrst_n |-> (!main_wrst_n && !iso_req));

  p_min_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_wrst_n) |-> (low_run >= (CNT_W+1)'(MIN_ASSERT)));

  p_key_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_wrst_n) |=> (bank_a_key != KEY_ARM && bank_b_key != KEY_ARM));

  for (genvar i = 0; i < NCAUSE; i++) begin : g_sticky
    p_cause_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cause_q[i]) |-> $past(clr_cause_we && clr_cause_data[i]));
  end
endmodule

bind warm_rst_keyed_ctrl wrk_checker #(.CNT_W(CNT_W), .MIN_ASSERT(MIN_ASSERT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .iso_ack        (iso_ack),
  .iso_req        (iso_req),
  .main_wrst_n    (main_wrst_n),
  .sec_wrst_n     (sec_wrst_n),
  .bank_a_key     (bank_a_key),
  .bank_b_key     (bank_b_key),
  .cause_q        (cause_q),
  .clr_cause_we   (clr_cause_we),
  .clr_cause_data (clr_cause_data)
);

// File: tb/warm_rst_keyed_ctrl_test.sv
`timescale 1ns/1ps
module warm_rst_keyed_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bank_a_we, bank_b_we, clr_cause_we, rst_req_pin_n, sec_indep, iso_ack;
  logic [3:0] bank_a_wdata, bank_b_wdata, bank_a_key, bank_b_key;
  logic [2:0] clr_cause_data, cause_q;
  logic [7:0] assert_cycles;
  logic       iso_req, main_wrst_n, sec_wrst_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] v;
    int         at;
    string      tag;
  } exp_t;
  exp_t       exp_q[$];
  exp_t       e;
  logic [2:0] last_v;
  logic [2:0] cur_v;

  warm_rst_keyed_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .bank_a_we(bank_a_we), .bank_a_wdata(bank_a_wdata),
    .bank_b_we(bank_b_we), .bank_b_wdata(bank_b_wdata),
    .clr_cause_we(clr_cause_we), .clr_cause_data(clr_cause_data),
    .rst_req_pin_n(rst_req_pin_n), .sec_indep(sec_indep),
    .assert_cycles(assert_cycles), .iso_ack(iso_ack),
    .bank_a_key(bank_a_key), .bank_b_key(bank_b_key), .cause_q(cause_q),
    .iso_req(iso_req), .main_wrst_n(main_wrst_n), .sec_wrst_n(sec_wrst_n)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic push(input logic [2:0] v, input int at, input string tag);
    exp_t x;
    x.v = v; x.at = at; x.tag = tag;
    exp_q.push_back(x);
  endtask

  // monitor: every change of {iso_req, main_wrst_n, sec_wrst_n} must match the queue head
  always @(negedge clk) begin
    if (mon_on) begin
      cur_v = {iso_req, main_wrst_n, sec_wrst_n};
      if (cur_v !== last_v) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2/R9 unexpected output change", int'(cur_v), int'(last_v));
        end else begin
          e = exp_q.pop_front();
          chk(cur_v === e.v, {e.tag, " output vector"}, int'(cur_v), int'(e.v));
          chk(cyc == e.at, {e.tag, " change cycle"}, cyc, e.at);
        end
      end
      last_v = cur_v;
    end
  end

  task automatic wr_key(input int bank, input logic [3:0] val);
    if (bank == 0) begin bank_a_we = 1'b1; bank_a_wdata = val; end
    else           begin bank_b_we = 1'b1; bank_b_wdata = val; end
    @(negedge clk);
    bank_a_we = 1'b0; bank_b_we = 1'b0;
  endtask

  task automatic clr_cause(input logic [2:0] m);
    clr_cause_we = 1'b1; clr_cause_data = m;
    @(negedge clk);
    clr_cause_we = 1'b0; clr_cause_data = '0;
    @(negedge clk);
  endtask

  // src: 0 bank A, 1 bank B, 2 pin, 3 both banks together
  task automatic run_seq(input int src, input bit indep, input logic [7:0] len,
                         input int gap, input string tag);
    int t, d, L, ta;
    sec_indep = indep;
    assert_cycles = len;
    t = cyc;
    d = (src == 2) ? 3 : 2;
    L = (len < 8'd16) ? 16 : int'(len);
    if (src == 0 || src == 3) begin bank_a_we = 1'b1; bank_a_wdata = 4'b0110; end
    if (src == 1 || src == 3) begin bank_b_we = 1'b1; bank_b_wdata = 4'b0110; end
    if (src == 2) rst_req_pin_n = 1'b0;
    @(negedge clk);
    bank_a_we = 1'b0; bank_b_we = 1'b0;
    if (indep) begin
      ta = t + d + gap + 1;
      push(3'b111, t + d, {tag, " R3 iso request"});
      push(3'b101, ta, {tag, " R3 main low after ack"});
      push(3'b011, ta + L, {tag, " R5 release"});
      wait_until(t + d + gap);
      chk(main_wrst_n === 1'b1, {tag, " R3 main held before ack"}, int'(main_wrst_n), 1);
      iso_ack = 1'b1;
      @(negedge clk);
      iso_ack = 1'b0;
    end else begin
      ta = t + d;
      push(3'b000, ta, {tag, " R4 both low"});
      push(3'b011, ta + L, {tag, " R5 release"});
    end
    wait_until(ta + L + 2);
    if (src == 2) rst_req_pin_n = 1'b1;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int t0;
    rst_n = 1'b0;
    bank_a_we = 0; bank_b_we = 0; bank_a_wdata = 4'hF; bank_b_wdata = 4'hF;
    clr_cause_we = 0; clr_cause_data = '0; rst_req_pin_n = 1'b1;
    sec_indep = 1'b1; iso_ack = 1'b0; assert_cycles = 8'd16;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(bank_a_key == 4'hF, "R1 bank A key", bank_a_key, 15);
    chk(bank_b_key == 4'hF, "R1 bank B key", bank_b_key, 15);
    chk(cause_q == 3'b000, "R1 cause", cause_q, 0);
    chk({iso_req, main_wrst_n, sec_wrst_n} == 3'b011, "R1 outputs",
        {iso_req, main_wrst_n, sec_wrst_n}, 3);
    last_v = 3'b011;
    mon_on = 1'b1;

    // R2 non-key values do nothing
    foreach (exp_q[i]) ; // queue empty here
    begin
      logic [3:0] vals [4] = '{4'b0000, 4'b0111, 4'b1110, 4'b1111};
      foreach (vals[k]) begin
        wr_key(k % 2, vals[k]);
        chk(((k % 2) ? bank_b_key : bank_a_key) == vals[k], "R2 readback",
            (k % 2) ? bank_b_key : bank_a_key, vals[k]);
        repeat (6) @(negedge clk);
      end
      chk(cause_q == 3'b000, "R2 no cause logged", cause_q, 0);
    end

    // R3 R5 R6 bank A, independent, 20 cycles
    run_seq(0, 1'b1, 8'd20, 3, "bankA indep");
    chk(bank_a_key == 4'hF, "R6 bank A restored", bank_a_key, 15);
    chk(cause_q == 3'b001, "R8 cause bank A", cause_q, 1);
    repeat (8) @(negedge clk);
    clr_cause(3'b111);

    // R4 R5 bank B, shared domain, short length clamps to 16
    run_seq(1, 1'b0, 8'd5, 0, "bankB shared");
    chk(bank_b_key == 4'hF, "R6 bank B restored", bank_b_key, 15);
    chk(cause_q == 3'b010, "R8 cause bank B", cause_q, 2);
    repeat (8) @(negedge clk);
    clr_cause(3'b111);

    // R7 pin request, independent, ack after 1 cycle
    run_seq(2, 1'b1, 8'd16, 1, "pin");
    chk(cause_q == 3'b100, "R7 cause pin", cause_q, 4);
    repeat (8) @(negedge clk);
    clr_cause(3'b111);

    // R8 simultaneous causes, write-1-to-clear per bit
    run_seq(3, 1'b0, 8'd17, 0, "both banks");
    chk(cause_q == 3'b011, "R8 both bits set", cause_q, 3);
    clr_cause(3'b001);
    chk(cause_q == 3'b010, "R8 clear bit0 only", cause_q, 2);
    clr_cause(3'b010);
    chk(cause_q == 3'b000, "R8 clear bit1", cause_q, 0);
    repeat (4) @(negedge clk);

    // R9 requests during a running sequence are only logged
    t0 = cyc;
    fork
      run_seq(0, 1'b1, 8'd20, 3, "inflight");
      begin
        wait_until(t0 + 6);
        wr_key(1, 4'b0110);
        wait_until(t0 + 12);
        rst_req_pin_n = 1'b0;
      end
    join
    repeat (12) @(negedge clk);
    rst_req_pin_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(bank_b_key == 4'hF, "R9 in-flight key restored", bank_b_key, 15);
    chk(cause_q == 3'b111, "R9 in-flight causes logged", cause_q, 7);
    chk(exp_q.size() == 0, "R9 pending expectations", exp_q.size(), 0);
    chk({iso_req, main_wrst_n, sec_wrst_n} == 3'b011, "R9 idle after",
        {iso_req, main_wrst_n, sec_wrst_n}, 3);
    finish_up();
  end
endmodule